// File: doc/BRIEF.md
# SD Host Data-Line Activity Tracker

This block keeps the data-line part of an SD host controller's present-state status. From single-cycle event strobes sent by the data and command engines, it works out whether a read transfer is in progress, whether a write transfer is in progress, and whether any data line is in use. It also derives a data command inhibit bit that gates the issue of new commands using the data lines. The first clock edge after that inhibit falls, a sticky transfer-complete flag is set.

Continue requests resume the direction of the most recent transfer. A write does not free the data lines when its CRC status arrives. The lines are freed only after the card's busy level has stayed low for `QUIET_CYCLES` consecutive clocks (default 8). A command issued with a busy response holds the inhibit until the same quiet period has passed. A data-line soft reset clears the status without reporting a completion.

All inputs are synchronous to `clk`. Every event input is a one-cycle strobe. `card_busy` is a level. Every status output is registered, so a change shows on the outputs just after the clock edge that samples the event.

Top module: `sdl_dat_status`

## Requirements
- R1: While `rst_n` is low, and just after it is released, `rd_active`, `wr_active`, `line_active`, `dat_inhibit` and `tc_flag` are all 0.
- R2: A `rd_cmd_end` strobe sets `rd_active` and `line_active` on the same edge. A `cont_req` strobe does the same when the most recent command was a read.
- R3: For a read, `last_blk_end` or `rdwait_enter` clears `line_active` and leaves `rd_active` unchanged. `host_read_done` clears `rd_active`.
- R4: `gap_stop` during a read clears both `rd_active` and `line_active`. A later `cont_req` sets both again.
- R5: A `wr_cmd_end` strobe sets `wr_active` and `line_active`. A `cont_req` does the same when the most recent command was a write.
- R6: `crc_last` clears `wr_active` on its edge. `line_active` falls on the eighth clock edge after that edge, provided `card_busy` stays low the whole time.
- R7: If `card_busy` is high during the quiet count, the count restarts. `line_active` then falls on the eighth edge after the last busy cycle.
- R8: `gap_stop` during a write clears `wr_active` at once. It frees `line_active` under the same quiet rule as R6.
- R9: `busy_cmd_issue` raises `dat_inhibit`. That condition is released after eight consecutive non-busy clocks, with the same restart rule as R7.
- R10: `dat_inhibit` is 1 exactly when `line_active`, `rd_active` or a pending busy command is set. `wr_active` alone does not raise it.
- R11: On the edge after `dat_inhibit` falls, `tc_flag` goes to 1. It stays at 1 until a `tc_clear` strobe. If the set and the clear happen in the same cycle, the set wins.
- R12: `dl_soft_rst` clears all four status bits and any pending busy condition. It never sets `tc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cmd_end | input | 1 | End bit of a read command seen |
| wr_cmd_end | input | 1 | End bit of a write command seen |
| cont_req | input | 1 | Continue request after a block-gap stop |
| gap_stop | input | 1 | Stop at block gap reached |
| host_read_done | input | 1 | Host has read all data of the last block |
| last_blk_end | input | 1 | End bit of the last received block |
| rdwait_enter | input | 1 | Read-wait mode entered |
| crc_last | input | 1 | CRC status of the last written block received |
| busy_cmd_issue | input | 1 | Command with busy response issued |
| card_busy | input | 1 | Card busy level on the data line |
| dl_soft_rst | input | 1 | Data-line soft reset strobe |
| tc_clear | input | 1 | Write-one-to-clear strobe for the flag |
| rd_active | output | 1 | Read transfer active |
| wr_active | output | 1 | Write transfer active |
| line_active | output | 1 | Data line in use |
| dat_inhibit | output | 1 | Data-line command inhibit |
| tc_flag | output | 1 | Sticky transfer-complete flag |

## Verification
The bound checker checks the following on every clock:
- that the start strobes set the status bits on the next cycle;
- that `crc_last` clears `wr_active`;
- that an active read or an active line always shows as inhibit;
- that a soft reset clears everything;
- that a fall of the inhibit is followed by the flag, and that the flag holds until cleared.

The exact length of the quiet window can only be shown by the bench's timed scenarios, counted edge by edge. The same holds for the restart on a busy cycle, for direction memory across continue requests, and for the set-over-clear priority of the flag.

// File: rtl/sdl_pkg.sv
// Package: shared types for the data-line activity tracker.
// Assumes all event fields are single-cycle strobes in the clk domain.
package sdl_pkg;

    // Direction of the most recent data transfer, used by continue requests.
    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } xfer_dir_e;

    // Bundle of transfer events delivered to the tracker.
    typedef struct packed {
        logic rd_cmd_end;
        logic wr_cmd_end;
        logic cont_req;
        logic gap_stop;
        logic host_read_done;
        logic last_blk_end;
        logic rdwait_enter;
        logic crc_last;
        logic busy_cmd_issue;
    } sdl_evt_t;

    // Counter width for a quiet window of n cycles (at least one bit).
    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/sdl_quiet_timer.sv
// Module: counts consecutive non-busy cycles while a release is armed.
// quiet_done pulses in the cycle that completes QUIET non-busy cycles.
// A busy cycle, a new arming event or disarming restarts the count from zero.
// Assumes QUIET >= 2.
module sdl_quiet_timer #(
    parameter int unsigned QUIET = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic restart,
    input  logic card_busy,
    output logic quiet_done
);
    localparam int unsigned CW = sdl_pkg::cnt_width(QUIET);
    localparam logic [CW-1:0] LAST = CW'(QUIET - 1);

    logic [CW-1:0] cnt_q;

    // Completion: last quiet cycle of an armed, undisturbed window.
    always_comb quiet_done = armed && !card_busy && !restart && (cnt_q == LAST);

    // Counter: advance on quiet armed cycles, otherwise return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!armed || card_busy || restart || quiet_done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sdl_xfer_track.sv
// Module: read/write/line activity state and pending busy releases.
// Remembers the last command direction for continue requests, and arms a
// quiet-period release for write line freeing and for busy commands.
// Priority: soft reset, then start events, then stop events.
module sdl_xfer_track
    import sdl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sdl_evt_t evt,
    input  logic     soft_rst,
    input  logic     quiet_done,
    output logic     rd_active,
    output logic     wr_active,
    output logic     line_active,
    output logic     busy_pend,
    output logic     armed,
    output logic     arm_evt
);
    xfer_dir_e dir_q;
    logic      rel_pend_q;
    logic      start_rd, start_wr, rd_stop, wr_stop, rd_line_off, wr_arm;

    // Event decode: starts, stops and arming conditions.
    always_comb begin
        start_rd    = evt.rd_cmd_end || (evt.cont_req && dir_q == DIR_RD);
        start_wr    = evt.wr_cmd_end || (evt.cont_req && dir_q == DIR_WR);
        rd_stop     = evt.host_read_done || evt.gap_stop;
        wr_stop     = evt.crc_last || evt.gap_stop;
        rd_line_off = (dir_q == DIR_RD) &&
                      (evt.last_blk_end || evt.rdwait_enter || evt.gap_stop);
        wr_arm      = evt.crc_last || (evt.gap_stop && dir_q == DIR_WR && line_active);
        arm_evt     = wr_arm || evt.busy_cmd_issue;
        armed       = rel_pend_q || busy_pend;
    end

    // Direction memory: follows the latest read or write command.
    always_ff @(posedge clk) begin
        if (!rst_n)                 dir_q <= DIR_RD;
        else if (evt.wr_cmd_end)    dir_q <= DIR_WR;
        else if (evt.rd_cmd_end)    dir_q <= DIR_RD;
    end

    // Read transfer active bit.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) rd_active <= 1'b0;
        else if (start_rd)      rd_active <= 1'b1;
        else if (rd_stop)       rd_active <= 1'b0;
    end

    // Write transfer active bit.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) wr_active <= 1'b0;
        else if (start_wr)      wr_active <= 1'b1;
        else if (wr_stop)       wr_active <= 1'b0;
    end

    // Pending write line release, waiting for the quiet window.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)       rel_pend_q <= 1'b0;
        else if (start_rd || start_wr) rel_pend_q <= 1'b0;
        else if (wr_arm)              rel_pend_q <= 1'b1;
        else if (quiet_done)          rel_pend_q <= 1'b0;
    end

    // Pending busy command, released by the quiet window.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)      busy_pend <= 1'b0;
        else if (evt.busy_cmd_issue) busy_pend <= 1'b1;
        else if (quiet_done)         busy_pend <= 1'b0;
    end

    // Data line active bit.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)              line_active <= 1'b0;
        else if (start_rd || start_wr)       line_active <= 1'b1;
        else if (rd_line_off)                line_active <= 1'b0;
        else if (quiet_done && rel_pend_q)   line_active <= 1'b0;
    end

endmodule

// File: rtl/sdl_tc_gen.sv
// Module: sticky transfer-complete flag raised one edge after inhibit falls.
// A fall caused by a soft reset is ignored. Set has priority over clear.
module sdl_tc_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic inhibit,
    input  logic soft_rst,
    input  logic tc_clear,
    output logic tc_flag
);
    logic inh_q, srst_q, fall_seen;

    // Fall detect on the registered inhibit, masked after a soft reset.
    always_comb fall_seen = inh_q && !inhibit && !srst_q;

    // History: previous inhibit and soft reset strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inh_q  <= 1'b0;
            srst_q <= 1'b0;
        end else begin
            inh_q  <= inhibit;
            srst_q <= soft_rst;
        end
    end

    // Flag: set on a fall, cleared by the write-one-to-clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)         tc_flag <= 1'b0;
        else if (fall_seen) tc_flag <= 1'b1;
        else if (tc_clear)  tc_flag <= 1'b0;
    end

endmodule

// File: rtl/sdl_dat_status.sv
// Top: SD host data-line activity status and transfer-complete flag.
// Inputs are clk-synchronous strobes except the card_busy level.
// QUIET_CYCLES sets the non-busy window before a busy release.
module sdl_dat_status #(
    parameter int unsigned QUIET_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cmd_end,
    input  logic wr_cmd_end,
    input  logic cont_req,
    input  logic gap_stop,
    input  logic host_read_done,
    input  logic last_blk_end,
    input  logic rdwait_enter,
    input  logic crc_last,
    input  logic busy_cmd_issue,
    input  logic card_busy,
    input  logic dl_soft_rst,
    input  logic tc_clear,
    output logic rd_active,
    output logic wr_active,
    output logic line_active,
    output logic dat_inhibit,
    output logic tc_flag
);
    import sdl_pkg::*;

    sdl_evt_t evt;
    logic     busy_pend, armed, arm_evt, quiet_done;

    // Pack the event strobes for the tracker.
    always_comb begin
        evt.rd_cmd_end     = rd_cmd_end;
        evt.wr_cmd_end     = wr_cmd_end;
        evt.cont_req       = cont_req;
        evt.gap_stop       = gap_stop;
        evt.host_read_done = host_read_done;
        evt.last_blk_end   = last_blk_end;
        evt.rdwait_enter   = rdwait_enter;
        evt.crc_last       = crc_last;
        evt.busy_cmd_issue = busy_cmd_issue;
    end

    sdl_xfer_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .soft_rst    (dl_soft_rst),
        .quiet_done  (quiet_done),
        .rd_active   (rd_active),
        .wr_active   (wr_active),
        .line_active (line_active),
        .busy_pend   (busy_pend),
        .armed       (armed),
        .arm_evt     (arm_evt)
    );

    sdl_quiet_timer #(.QUIET(QUIET_CYCLES)) u_quiet (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (armed),
        .restart    (arm_evt),
        .card_busy  (card_busy),
        .quiet_done (quiet_done)
    );

    // Inhibit: any condition that keeps the data lines owned.
    always_comb dat_inhibit = line_active || rd_active || busy_pend;

    sdl_tc_gen u_tc (
        .clk      (clk),
        .rst_n    (rst_n),
        .inhibit  (dat_inhibit),
        .soft_rst (dl_soft_rst),
        .tc_clear (tc_clear),
        .tc_flag  (tc_flag)
    );

endmodule

// File: rtl/sdl_dat_status_chk.sv
// Checker: cycle-level properties of the data-line status block, bound to the top.
module sdl_dat_status_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_cmd_end,
    input logic wr_cmd_end,
    input logic cont_req,
    input logic crc_last,
    input logic gap_stop,
    input logic dl_soft_rst,
    input logic tc_clear,
    input logic rd_active,
    input logic wr_active,
    input logic line_active,
    input logic dat_inhibit,
    input logic tc_flag
);
    AST_RD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd_end && !dl_soft_rst) |=> (rd_active && line_active)); // R2
    AST_WR_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_end && !dl_soft_rst) |=> (wr_active && line_active)); // R5
    AST_CRC_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_last && !wr_cmd_end && !cont_req) |=> !wr_active); // R6
    AST_RD_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active || line_active) |-> dat_inhibit); // R10
    AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        dl_soft_rst |=> (!rd_active && !wr_active && !line_active && !dat_inhibit)); // R12
    AST_TC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dat_inhibit) && !$past(dl_soft_rst)) |=> tc_flag); // R11
    AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_flag && !tc_clear) |=> tc_flag); // R11
    AST_NO_TC_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_soft_rst && !tc_flag && !dat_inhibit) |=> !tc_flag); // R12
endmodule

bind sdl_dat_status sdl_dat_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_cmd_end  (rd_cmd_end),
    .wr_cmd_end  (wr_cmd_end),
    .cont_req    (cont_req),
    .crc_last    (crc_last),
    .gap_stop    (gap_stop),
    .dl_soft_rst (dl_soft_rst),
    .tc_clear    (tc_clear),
    .rd_active   (rd_active),
    .wr_active   (wr_active),
    .line_active (line_active),
    .dat_inhibit (dat_inhibit),
    .tc_flag     (tc_flag)
);

// File: tb/sim_sdl_dat_status.sv
// Bench for sdl_dat_status: vector table for the read flow, then directed tests.
module sim_sdl_dat_status;
    localparam int CLK_PERIOD = 10;

    // Stimulus bit order: rd, wr, cont, gap, hrd, lbe, rwait, crc, bcmd, busy, srst, tcc
    localparam logic [11:0] S_IDLE = 12'h000;
    localparam logic [11:0] S_RD   = 12'h800;
    localparam logic [11:0] S_WR   = 12'h400;
    localparam logic [11:0] S_CONT = 12'h200;
    localparam logic [11:0] S_GAP  = 12'h100;
    localparam logic [11:0] S_HRD  = 12'h080;
    localparam logic [11:0] S_LBE  = 12'h040;
    localparam logic [11:0] S_RW   = 12'h020;
    localparam logic [11:0] S_CRC  = 12'h010;
    localparam logic [11:0] S_BCMD = 12'h008;
    localparam logic [11:0] S_BUSY = 12'h004;
    localparam logic [11:0] S_SRST = 12'h002;
    localparam logic [11:0] S_TCC  = 12'h001;

    // Expected after the edge: {rd_active, wr_active, line_active, dat_inhibit, tc_flag}
    localparam int NV = 17;
    localparam logic [16:0] VEC [NV] = '{
        {S_IDLE, 5'b00000},  // R1 idle after reset
        {S_RD,   5'b10110},  // R2 read start
        {S_IDLE, 5'b10110},  // R2 held
        {S_RW,   5'b10010},  // R3 read-wait frees line only
        {S_CONT, 5'b10110},  // R4 continue resumes read
        {S_GAP,  5'b00000},  // R4 gap stop clears both
        {S_IDLE, 5'b00001},  // R11 flag after inhibit fall
        {S_TCC,  5'b00000},  // R11 clear
        {S_CONT, 5'b10110},  // R4 continue after gap
        {S_LBE,  5'b10010},  // R3 last block end frees line
        {S_HRD,  5'b00000},  // R3 host read done
        {S_IDLE, 5'b00001},  // R11 flag
        {S_IDLE, 5'b00001},  // R11 sticky
        {S_TCC,  5'b00000},  // R11 clear
        {S_RD,   5'b10110},  // R2 read again
        {S_SRST, 5'b00000},  // R12 soft reset
        {S_IDLE, 5'b00000}   // R12 no flag after soft reset
    };

    logic clk = 1'b0;
    logic rst_n;
    logic rd_cmd_end, wr_cmd_end, cont_req, gap_stop, host_read_done, last_blk_end;
    logic rdwait_enter, crc_last, busy_cmd_issue, card_busy, dl_soft_rst, tc_clear;
    logic rd_active, wr_active, line_active, dat_inhibit, tc_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdl_dat_status u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_cmd_end(rd_cmd_end), .wr_cmd_end(wr_cmd_end), .cont_req(cont_req),
        .gap_stop(gap_stop), .host_read_done(host_read_done), .last_blk_end(last_blk_end),
        .rdwait_enter(rdwait_enter), .crc_last(crc_last), .busy_cmd_issue(busy_cmd_issue),
        .card_busy(card_busy), .dl_soft_rst(dl_soft_rst), .tc_clear(tc_clear),
        .rd_active(rd_active), .wr_active(wr_active), .line_active(line_active),
        .dat_inhibit(dat_inhibit), .tc_flag(tc_flag)
    );

    // Drive one cycle of stimulus at a falling edge and wait for the next one.
    task automatic step(input logic [11:0] s);
        {rd_cmd_end, wr_cmd_end, cont_req, gap_stop, host_read_done, last_blk_end,
         rdwait_enter, crc_last, busy_cmd_issue, card_busy, dl_soft_rst, tc_clear} = s;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(S_IDLE);
    endtask

    // Compare all five outputs against an expectation.
    task automatic expect5(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {rd_active, wr_active, line_active, dat_inhibit, tc_flag};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: outputs actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        {rd_cmd_end, wr_cmd_end, cont_req, gap_stop, host_read_done, last_blk_end,
         rdwait_enter, crc_last, busy_cmd_issue, card_busy, dl_soft_rst, tc_clear} = '0;
        repeat (3) @(negedge clk);
        expect5("R1 in reset", 5'b00000);
        rst_n = 1'b1;

        // Vector table: read-direction flow
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][16:5]);
            checks++;
            if ({rd_active, wr_active, line_active, dat_inhibit, tc_flag} !== VEC[v][4:0]) begin
                failures++;
                $display("FAIL table row %0d (R1 R2 R3 R4 R11 R12): actual=%b expected=%b", v,
                         {rd_active, wr_active, line_active, dat_inhibit, tc_flag}, VEC[v][4:0]);
            end
        end

        // R5 write start, R10 inhibit follows the line
        step(S_WR);
        expect5("R5 write start", 5'b01110);
        // R6 quiet window of eight edges after CRC status
        step(S_CRC);
        expect5("R6 crc clears wr_active", 5'b00110);
        idle(7);
        expect5("R6 line held 7 edges", 5'b00110);
        idle(1);
        expect5("R6 line freed on 8th edge", 5'b00000);
        idle(1);
        expect5("R11 flag after write", 5'b00001);
        step(S_TCC);

        // R7 busy cycle restarts the count
        step(S_WR);
        step(S_CRC);
        idle(4);
        step(S_BUSY);
        idle(7);
        expect5("R7 line held after restart", 5'b00110);
        idle(1);
        expect5("R7 line freed 8 edges after busy", 5'b00000);
        idle(1);
        step(S_TCC);
        expect5("R11 clear after R7", 5'b00000);

        // R8 gap stop during write, then continue
        step(S_WR);
        step(S_GAP);
        expect5("R8 gap stop clears wr_active", 5'b00110);
        idle(8);
        expect5("R8 line freed after quiet", 5'b00000);
        idle(1);
        step(S_CONT | S_TCC);
        expect5("R8 continue resumes write", 5'b01110);
        step(S_CRC);
        idle(8);
        step(S_TCC);
        expect5("R11 set wins over clear", 5'b00001);
        step(S_TCC);
        expect5("R11 clear", 5'b00000);

        // R9 busy command holds inhibit through busy and quiet window
        step(S_BCMD | S_BUSY);
        expect5("R9 busy command inhibits", 5'b00010);
        step(S_BUSY);
        step(S_BUSY);
        idle(7);
        expect5("R9 still inhibited", 5'b00010);
        idle(1);
        expect5("R9 released", 5'b00000);
        idle(1);
        expect5("R11 flag after busy release", 5'b00001);
        step(S_TCC);

        // R12 soft reset during write and during busy command
        step(S_WR);
        step(S_SRST);
        expect5("R12 soft reset clears write", 5'b00000);
        step(S_BCMD | S_BUSY);
        step(S_SRST);
        expect5("R12 soft reset clears busy cmd", 5'b00000);
        idle(2);
        expect5("R12 no flag after soft reset", 5'b00000);

        finish_run();
    end

endmodule